// File: doc/BRIEF.md
# Prescaled Backlight PWM Generator

This block produces one pulse-width-modulated output for a display backlight, counted directly from the reference clock. Two cascaded counters set the timing. A prescale counter divides the reference clock by an 8-bit divider. A 16-bit main counter advances on each prescale tick and restarts after it reaches the scale value. One full period therefore lasts divider × scale + 1 reference clocks. The output is high from the start of a period until the main counter reaches the 16-bit level value.

Software programs the block through a byte-wide register port: address, write data, write strobe and combinational read data. Each 16-bit value is split across two byte registers, low byte first. One control register holds both the enable bit and the invert bit. A pin control register selects the pin function, and the waveform reaches the pin only when that selection is the PWM function. The counters take the programmed divider, scale and level only at the start of a period, so no period ever mixes old and new settings.

Top module: `bl_pwm`

## Requirements
- R1: The registers sit at these addresses: divider 0, scale low/high 1/2, level low/high 3/4, control 5, pin control 6. All reset to 0 and read back what was written. Address 7 reads 0 and ignores writes.
- R2: Each 16-bit value is little-endian: the low byte is at the base address and the high byte at base+1.
- R3: While enabled, one output period lasts divider × scale + 1 reference clocks.
- R4: When 0 < level < scale, the waveform is high for the first level × divider clocks of each period and low for the rest.
- R5: A level of 0 gives a constant low waveform. A level of scale or more, with level not 0, gives a constant high waveform.
- R6: A divider value of 0 acts as 1.
- R7: Control bit 1 is the enable and control bit 0 inverts the output. While disabled, the output holds the value of the invert bit.
- R8: The output is driven (pwm_oe_o = 1) only when pin control bits [7:6] equal 2'b10. Otherwise pwm_oe_o = 0 and pwm_o = 0.
- R9: New divider, scale and level values take effect only at the start of the next period. A write in mid-period leaves the current period unchanged.
- R10: With divider 1 and scale 1, the period is 2 clocks, so a new level takes effect within two clocks of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| pwm_o | output | 1 | PWM output |
| pwm_oe_o | output | 1 | Pin drive enable (pin muxed to PWM) |

## Verification
The assertions check on every cycle that:
- the prescale and main counters stay inside their active limits;
- the captured settings hold steady until a period restarts;
- the pin gating and the disabled idle level are correct;
- a write lands in its register.

Only the bench scenarios can show the period length, the high time, the byte order, the zero-divider substitution and the effect of a mid-period write. The bench compares against a reference model that tracks the position in the period as a single integer, not as two nested counters.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned NUM_REGS = 7;

  localparam int unsigned IDX_PRE    = 0;
  localparam int unsigned IDX_SCL_LO = 1;
  localparam int unsigned IDX_SCL_HI = 2;
  localparam int unsigned IDX_LVL_LO = 3;
  localparam int unsigned IDX_LVL_HI = 4;
  localparam int unsigned IDX_CTRL   = 5;
  localparam int unsigned IDX_PIN    = 6;

  localparam int unsigned CTRL_INV_BIT = 0;
  localparam int unsigned CTRL_EN_BIT  = 1;
  localparam int unsigned PIN_FN_LSB   = 6;
  localparam logic [1:0]  PIN_FN_PWM   = 2'b10;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int unsigned PW = REG_W,
  parameter int unsigned CW = 2 * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              we_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [PW-1:0]     pre_o,
  output logic [CW-1:0]     scale_o,
  output logic [CW-1:0]     level_o,
  output logic              en_o,
  output logic              inv_o,
  output logic [1:0]        pin_fn_o
);
  logic [REG_W-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (we_i && addr_i == ADDR_W'(i)) regs_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = regs_q[i];
  end

  assign pre_o    = regs_q[IDX_PRE][PW-1:0];
  assign scale_o  = CW'({regs_q[IDX_SCL_HI], regs_q[IDX_SCL_LO]});
  assign level_o  = CW'({regs_q[IDX_LVL_HI], regs_q[IDX_LVL_LO]});
  assign en_o     = regs_q[IDX_CTRL][CTRL_EN_BIT];
  assign inv_o    = regs_q[IDX_CTRL][CTRL_INV_BIT];
  assign pin_fn_o = regs_q[IDX_PIN][PIN_FN_LSB +: 2];

  // R1
  wr_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(IDX_CTRL)) |=> (en_o == $past(wdata_i[CTRL_EN_BIT])
                                               && inv_o == $past(wdata_i[CTRL_INV_BIT])));
endmodule

// File: rtl/bl_pwm_presc.sv
module bl_pwm_presc #(
  parameter int unsigned PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [PW-1:0] div_i,
  output logic          tick_o
);
  logic [PW-1:0] pc_q;
  logic [PW-1:0] div_eff;

  assign div_eff = (div_i == '0) ? PW'(1) : div_i;
  assign tick_o  = run_i && (pc_q == div_eff - PW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pc_q <= '0;
    else if (!run_i)       pc_q <= '0;
    else if (tick_o)       pc_q <= '0;
    else                   pc_q <= pc_q + PW'(1);
  end

  // R6
  pc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q < div_eff);
endmodule

// File: rtl/bl_pwm_period.sv
module bl_pwm_period #(
  parameter int unsigned PW = 8,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [PW-1:0] pre_i,
  input  logic [CW-1:0] scale_i,
  input  logic [CW-1:0] level_i,
  output logic [PW-1:0] act_pre_o,
  output logic          restart_o,
  output logic          run_o,
  output logic          wave_o
);
  logic [CW-1:0] mc_q;
  logic [CW-1:0] act_scale_q;
  logic [CW-1:0] act_level_q;
  logic [PW-1:0] act_pre_q;

  assign restart_o = (mc_q == act_scale_q);
  assign run_o     = en_i && !restart_o;
  assign act_pre_o = act_pre_q;

  // settings are sampled only while idle or on the restart clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mc_q        <= '0;
      act_scale_q <= '0;
      act_level_q <= '0;
      act_pre_q   <= '0;
    end else if (!en_i || restart_o) begin
      mc_q        <= '0;
      act_scale_q <= scale_i;
      act_level_q <= level_i;
      act_pre_q   <= pre_i;
    end else if (tick_i) begin
      mc_q <= mc_q + CW'(1);
    end
  end

  assign wave_o = (act_level_q != '0) &&
                  ((mc_q < act_level_q) || (act_level_q >= act_scale_q));

  // R3
  mc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_q <= act_scale_q);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !restart_o) |=> ($stable(act_scale_q) && $stable(act_level_q)
                              && $stable(act_pre_q)));
endmodule

// File: rtl/bl_pwm.sv
module bl_pwm
  import bl_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              we_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              pwm_o,
  output logic              pwm_oe_o
);
  localparam int unsigned PW = REG_W;
  localparam int unsigned CW = 2 * REG_W;

  logic [PW-1:0] pre, act_pre;
  logic [CW-1:0] scale, level;
  logic          en, inv, tick, restart, run, wave, pin_ok;
  logic [1:0]    pin_fn;

  bl_pwm_regs #(.PW(PW), .CW(CW)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .rdata_o,
    .pre_o(pre), .scale_o(scale), .level_o(level),
    .en_o(en), .inv_o(inv), .pin_fn_o(pin_fn)
  );

  bl_pwm_presc #(.PW(PW)) u_presc (
    .clk_i, .rst_ni, .run_i(run), .div_i(act_pre), .tick_o(tick)
  );

  bl_pwm_period #(.PW(PW), .CW(CW)) u_period (
    .clk_i, .rst_ni, .en_i(en), .tick_i(tick),
    .pre_i(pre), .scale_i(scale), .level_i(level),
    .act_pre_o(act_pre), .restart_o(restart), .run_o(run), .wave_o(wave)
  );

  assign pin_ok   = (pin_fn == PIN_FN_PWM);
  assign pwm_oe_o = pin_ok;
  assign pwm_o    = pin_ok && (en ? (wave ^ inv) : inv);

  // R8
  pin_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_fn != PIN_FN_PWM) |-> (!pwm_oe_o && !pwm_o));

  // R7
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_ok && !en) |-> (pwm_o == inv));
endmodule

// File: tb/bl_pwm_tb.sv
module bl_pwm_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] rdata_o;
  logic       pwm_o, pwm_oe_o;

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  bl_pwm u_dut (.*);

  always #4 clk_i = ~clk_i;

  // reference model: position inside the period as one integer
  int         m_t, m_p, m_s, m_bl;
  logic [7:0] m_r [8];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_t = 0; m_p = 1; m_s = 0; m_bl = 0;
      for (int i = 0; i < 8; i++) m_r[i] = '0;
    end else begin
      if (!m_r[5][1] || m_t == m_p * m_s) begin
        m_t  = 0;
        m_p  = (m_r[0] == 0) ? 1 : int'(m_r[0]);
        m_s  = int'({m_r[2], m_r[1]});
        m_bl = int'({m_r[4], m_r[3]});
      end else m_t++;
      if (we_i && addr_i < 3'd7) m_r[addr_i] = wdata_i;
    end
  end

  function automatic logic exp_pwm();
    int  mp;
    logic w;
    if (m_r[6][7:6] != 2'b10) return 1'b0;
    if (!m_r[5][1]) return m_r[5][0];
    mp = (m_t < m_p * m_s) ? m_t / m_p : m_s;
    w  = (m_bl != 0) && (mp < m_bl || m_bl >= m_s);
    return w ^ m_r[5][0];
  endfunction

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    #1;
    if (rst_ni && !done) begin
      chk(int'(pwm_o), int'(exp_pwm()), "model pwm_o");
      chk(int'(pwm_oe_o), int'(m_r[6][7:6] == 2'b10), "model pwm_oe_o");
      chk(int'(rdata_o), (addr_i < 3'd7) ? int'(m_r[addr_i]) : 0, "model rdata_o");
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog %s act=%0d exp=0", cur_req, cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    addr_i = 3'(a); wdata_i = 8'(d); we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp);
    @(negedge clk_i);
    addr_i = 3'(a);
    #2;
    chk(int'(rdata_o), exp, $sformatf("rdata addr %0d", a));
  endtask

  task automatic cfg(input int p, input int s, input int bl);
    wr(5, 0);
    wr(0, p & 8'hFF);
    wr(1, s & 8'hFF); wr(2, (s >> 8) & 8'hFF);
    wr(3, bl & 8'hFF); wr(4, (bl >> 8) & 8'hFF);
  endtask

  task automatic measure(output int hi, output int per);
    int lo;
    hi = 0; lo = 0;
    @(negedge clk_i);
    while (pwm_o !== 1'b0) @(negedge clk_i);
    while (pwm_o !== 1'b1) @(negedge clk_i);
    while (pwm_o === 1'b1) begin hi++; @(negedge clk_i); end
    while (pwm_o === 1'b0) begin lo++; @(negedge clk_i); end
    per = hi + lo;
  endtask

  task automatic hold_chk(input int n, input int exp, input string what);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (pwm_o !== 1'(exp)) bad++;
    end
    chk(bad, 0, what);
  endtask

  initial begin
    int hi, per;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state and map
    cur_req = "R1";
    for (int a = 0; a < 8; a++) rd_chk(a, 0);
    chk(int'(pwm_oe_o), 0, "reset oe");
    chk(int'(pwm_o), 0, "reset pwm");
    wr(0, 8'h5A); rd_chk(0, 8'h5A);
    wr(6, 8'h3C); rd_chk(6, 8'h3C);
    wr(7, 8'hFF); rd_chk(7, 0);

    // R8 pin function gating
    cur_req = "R8";
    cfg(3, 10, 4);
    wr(6, 8'h40); wr(5, 2);
    hold_chk(40, 0, "pin fn 01 gated");
    chk(int'(pwm_oe_o), 0, "oe fn 01");
    wr(6, 8'hC0);
    hold_chk(40, 0, "pin fn 11 gated");
    wr(6, 8'h80);
    @(negedge clk_i);
    chk(int'(pwm_oe_o), 1, "oe fn 10");

    // R3 R4 period and high time
    cur_req = "R3";
    cfg(3, 10, 4); wr(5, 2);
    measure(hi, per);
    chk(per, 31, "period P=3 S=10");
    cur_req = "R4";
    chk(hi, 12, "high P=3 S=10 L=4");

    // R7 invert and idle level
    cur_req = "R7";
    wr(5, 3);
    measure(hi, per);
    chk(hi, 19, "inverted high");
    chk(per, 31, "inverted period");
    wr(5, 1);
    hold_chk(30, 1, "disabled inv idle");
    wr(5, 0);
    hold_chk(30, 0, "disabled idle");

    // R2 byte order
    cur_req = "R2";
    cfg(1, 16'h0102, 16'h0100); wr(5, 2);
    rd_chk(1, 8'h02); rd_chk(2, 8'h01);
    rd_chk(3, 8'h00); rd_chk(4, 8'h01);
    measure(hi, per);
    chk(per, 259, "period 16b");
    chk(hi, 256, "high 16b");

    // R5 level extremes
    cur_req = "R5";
    cfg(3, 10, 10); wr(5, 2);
    hold_chk(80, 1, "level == scale");
    cfg(3, 10, 15); wr(5, 2);
    hold_chk(80, 1, "level > scale");
    cfg(3, 10, 0); wr(5, 2);
    hold_chk(80, 0, "level zero");

    // R6 zero divider
    cur_req = "R6";
    cfg(0, 10, 4); wr(5, 2);
    measure(hi, per);
    chk(per, 11, "period div0");
    chk(hi, 4, "high div0");

    // R10 minimum period
    cur_req = "R10";
    cfg(1, 1, 1); wr(5, 2);
    hold_chk(20, 1, "min period level1");
    wr(3, 0);
    @(negedge clk_i); @(negedge clk_i);
    chk(int'(pwm_o), 0, "min period update latency");

    // R9 mid-period update
    cur_req = "R9";
    cfg(2, 20, 5); wr(5, 2);
    @(negedge clk_i);
    while (pwm_o !== 1'b0) @(negedge clk_i);
    while (pwm_o !== 1'b1) @(negedge clk_i);
    repeat (15) @(negedge clk_i);
    wr(3, 15);
    chk(int'(pwm_o), 0, "no mid-period change");
    measure(hi, per);
    chk(hi, 30, "new level next period");
    chk(per, 41, "period after update");

    repeat (5) @(negedge clk_i);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule